// File: doc/BRIEF.md
# Bus-Mapped GPIO Port With Alternate-Function Select

This block is a single port of up to eight bidirectional pins behind a small register bus. Each pin is either a plain GPIO, whose direction and output level come from a data register, or it is handed to an alternate peripheral, whose output and output-enable then drive the pad directly. The block also samples live pin levels through a two-flop synchronizer. It keeps a snapshot of the pin levels seen just after reset.

Software reaches the port through three word addresses. The first is the data word, which packs direction, output, the reset snapshot and the live input. The second is a write-only set word, which raises chosen output bits without a read-modify-write. The third is the function-select word. A low-power input freezes whatever the pads are driven with, so the pins keep their state through a power-saving period.

Top module: `gpio_port`

## Requirements
- R1: After reset, every function field reads 0, direction and output are 0, and `pin_oe` is all zero.
- R2: The function word at offset 0x8 holds pin n's 2-bit code at bits [4n+1:4n]. All other bits read as zero, even after 1s are written to them.
- R3: Code 01 routes `alt_out` and `alt_oe` of that pin to `pin_out` and `pin_oe` in the same cycle. Codes 00, 10 and 11 give GPIO behaviour.
- R4: A read of offset 0x0 returns direction in bits 31:24, output in bits 23:16, the reset snapshot in bits 15:8 and the synchronized input in bits 7:0.
- R5: In GPIO mode a direction bit of 1 drives `pin_oe` high for that pin, and `pin_out` follows the output bit.
- R6: A write to offset 0x0 loads direction and output from bits 31:16. Bits 15:0 of that write change nothing.
- R7: A write to offset 0x4 sets each output bit whose matching bit in 23:16 is 1. It leaves every other output bit and the direction unchanged. A read of 0x4 returns zero.
- R8: A change on `pin_in` shows in input bits 7:0 after the second rising edge, and not after the first.
- R9: The snapshot holds the pin levels sampled at the first rising edge after reset release. Later pin changes do not alter it.
- R10: While `lp_hold` is high, `pin_out` and `pin_oe` keep their values from before it rose, even across register writes. When it falls, the live values return at once.
- R11: Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_hold | input | 1 | Freeze pad output and enable |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| alt_out | input | NPINS | Peripheral output per pin |
| alt_oe | input | NPINS | Peripheral output enable per pin |
| alt_in | output | NPINS | Synchronized pin levels to peripherals |

## Verification
Register writes take effect at the strobed rising edge. Read data and pad outputs are combinational from the registers, so the bench drives on the falling edge and samples one time unit after the next falling edge. Alternate-function routing and the release of `lp_hold` are checked in the same cycle they change. The input field is sampled after the first and after the second rising edge past a pin change, and only the second shows the new level. The snapshot is checked after the inputs have moved away from their reset-time value.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPINS    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int SET_OFS  = 4,
  parameter int CTL_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_hold,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic [NPINS-1:0]  alt_in
);
  localparam int STRIDE = 4;
  localparam int DIR_LSB = 24;
  localparam int OUT_LSB = 16;
  localparam int SNP_LSB = 8;

  logic [1:0]       fsel [NPINS];
  logic [NPINS-1:0] dir_q, dout_q, snap_q, sync1_q, sync2_q;
  logic [NPINS-1:0] hold_out_q, hold_oe_q, alt_sel, live_out, live_oe;
  logic [1:0]       fill_q;
  logic             snap_done_q;
  logic [31:0]      ctl_rd, data_rd;

  wire hit_data = bus_addr == ADDR_W'(DATA_OFS);
  wire hit_set  = bus_addr == ADDR_W'(SET_OFS);
  wire hit_ctl  = bus_addr == ADDR_W'(CTL_OFS);

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) fsel[n] <= 2'b00;
      else if (bus_wr && hit_ctl) fsel[n] <= bus_wdata[STRIDE*n +: 2];
    assign alt_sel[n] = fsel[n] == 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else if (bus_wr && hit_data) begin
      dir_q  <= bus_wdata[DIR_LSB +: NPINS];
      dout_q <= bus_wdata[OUT_LSB +: NPINS];
    end else if (bus_wr && hit_set) begin
      dout_q <= dout_q | bus_wdata[OUT_LSB +: NPINS];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q     <= '0;
      sync2_q     <= '0;
      fill_q      <= '0;
      snap_done_q <= 1'b0;
      snap_q      <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
      if (fill_q == 2'd2 && !snap_done_q) begin
        snap_q      <= sync2_q;
        snap_done_q <= 1'b1;
      end
    end

  assign live_out = (alt_sel & alt_out) | (~alt_sel & dout_q);
  assign live_oe  = (alt_sel & alt_oe)  | (~alt_sel & dir_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_out_q <= '0;
      hold_oe_q  <= '0;
    end else if (!lp_hold) begin
      hold_out_q <= live_out;
      hold_oe_q  <= live_oe;
    end

  assign pin_out = lp_hold ? hold_out_q : live_out;
  assign pin_oe  = lp_hold ? hold_oe_q  : live_oe;
  assign alt_in  = sync2_q;

  always_comb begin
    ctl_rd  = '0;
    data_rd = '0;
    for (int n = 0; n < NPINS; n++) ctl_rd[STRIDE*n +: 2] = fsel[n];
    data_rd[DIR_LSB +: NPINS] = dir_q;
    data_rd[OUT_LSB +: NPINS] = dout_q;
    data_rd[SNP_LSB +: NPINS] = snap_q;
    data_rd[0 +: NPINS]       = sync2_q;
  end

  assign bus_rdata = hit_data ? data_rd : hit_ctl ? ctl_rd : 32'h0;

  localparam logic [31:0] CTL_MASK = 32'h3333_3333;

  AST_CTL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ctl |-> (bus_rdata & ~CTL_MASK) == 32'h0); // R2
  AST_SET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set || !(hit_data || hit_ctl)) |-> bus_rdata == 32'h0); // R7
  AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_set) |=> ((dout_q & $past(dout_q)) == $past(dout_q)) && $stable(dir_q)); // R7
  AST_SNAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_done_q && $past(snap_done_q)) |-> $stable(snap_q)); // R9
  AST_FREEZE_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_hold && $past(lp_hold)) |-> ($stable(pin_out) && $stable(pin_oe))); // R10
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic clk = 0, rst_n = 0, lp_hold = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NP-1:0] pin_in = 8'hA5, pin_out, pin_oe, alt_out = 0, alt_oe = 0, alt_in;
  int checks = 0, fails = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (.clk, .rst_n, .lp_hold, .bus_addr, .bus_wr, .bus_wdata,
    .bus_rdata, .pin_in, .pin_out, .pin_oe, .alt_out, .alt_oe, .alt_in);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; #1;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R1 oe", pin_oe, 0);
    rd(4'h8, d); chk("R1 ctl", d, 0);
    rd(4'h0, d); chk("R4/R9 data", d, 32'h0000_A53C);
  endtask

  task automatic t_data;
    logic [31:0] d;
    wr(4'h0, 32'hF033_FFFF);
    rd(4'h0, d); chk("R6 data", d, 32'hF033_A53C);
    chk("R5 oe", pin_oe, 8'hF0);
    chk("R5 out", pin_out, 8'h33);
  endtask

  task automatic t_set;
    logic [31:0] d;
    wr(4'h4, 32'hFFC4_FFFF);
    rd(4'h0, d); chk("R7 set", d, 32'hF0F7_A53C);
    rd(4'h4, d); chk("R7 read", d, 0);
  endtask

  task automatic t_func;
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R2 mask", d, 32'h3333_3333);
    chk("R3 code11", pin_oe, 8'hF0);
    wr(4'h8, 32'h0020_1001);
    rd(4'h8, d); chk("R2 fields", d, 32'h0020_1001);
    alt_oe = 8'hFF; alt_out = 8'h00; #1;
    chk("R3 alt oe", pin_oe, 8'hF9);
    chk("R3 alt out", pin_out, 8'hF6);
    alt_out = 8'h08; #1;
    chk("R3 alt same cycle", pin_out, 8'hFE);
    wr(4'h8, 0);
    chk("R3 gpio back", pin_out, 8'hF7);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); rd(4'h0, d); chk("R8 one edge", d[7:0], 8'h3C);
    @(negedge clk); rd(4'h0, d); chk("R8 two edges", d[7:0], 8'h5A);
    chk("R8 alt_in", alt_in, 8'h5A);
    chk("R9 snap kept", d[15:8], 8'hA5);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    @(negedge clk); lp_hold = 1;
    wr(4'h0, 32'h0F0F_0000);
    chk("R10 out held", pin_out, 8'hF7);
    chk("R10 oe held", pin_oe, 8'hF0);
    rd(4'h0, d); chk("R10 regs", d[31:16], 16'h0F0F);
    @(negedge clk); lp_hold = 0; #1;
    chk("R10 release", {pin_oe, pin_out}, 16'h0F0F);
  endtask

  task automatic t_addr;
    logic [31:0] d;
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R11 read", d, 0);
    rd(4'h0, d); chk("R11 data", d[31:16], 16'h0F0F);
    rd(4'h8, d); chk("R11 ctl", d, 0);
  endtask

  initial begin
    t_reset; t_data; t_set; t_func; t_sync; t_freeze; t_addr;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule